// File: doc/BRIEF.md
# Seek Command Acceptance Controller

This block sits between a host interface and the positioner control of a disk drive. It takes the host's cylinder address strobe and decides whether the cylinder address that comes with it should be loaded into the demand register. It also decides whether a restore should start or whether the command must be flagged as illegal. It drives the busy status the host sees. Busy rises as soon as a strobe is seen and is held for a short delay after the strobe ends. If the servo leaves position mode, busy is then held for the whole seek.

The end of a seek is timed by a settle chain. Once position mode comes back, ones move through the chain, one stage per slow settle tick. When the last stage fills, a one-clock end-busy pulse ends the seek-busy interval and any restore in progress. The strobe, the restore request, selected-ready, ready, position mode and heads-loaded are asynchronous and pass through two-flop synchronizers. The cylinder address must stay stable while the strobe is active. The settle tick is synchronous to the block clock.

Top module: `seek_accept_ctrl`

## Requirements
- R1: While selected-ready is low, strobes have no effect: busy does not rise, and no load, restore-start or illegal event occurs.
- R2: Busy rises while a strobe is active and stays high for HOLD_LEN (default 4) clocks after the strobe's falling edge has been synchronized. It then falls unless a seek has started.
- R3: At a strobe's trailing edge, load_pulse_o is high for exactly one clock when all three of these hold: the address is in 0..MAX_CYL (default 405), the restore request is low, and no seek is busy.
- R4: At a strobe's trailing edge with the restore request high, restore_start_o pulses for one clock and restore_o sets. The address is disregarded: there is no load and no illegal flag.
- R5: At a non-restore trailing edge, the illegal flag sets if the address is above MAX_CYL or a seek is busy.
- R6: The illegal flag clears on a load pulse, on a restore start, or while heads_loaded_i is low.
- R7: illegal_o shows the flag only while selected-ready is high, and it is forced low while the second strobe stage is active.
- R8: A falling edge of position mode sets seek-busy, which keeps busy high, and it empties the settle chain.
- R9: While position mode is high, the settle chain advances only on settle_tick_i. When all SETTLE_LEN (default 8) stages are full and a seek or restore is active, end_busy_o pulses, and seek-busy and restore_o clear.
- R10: While ready is low, both busy flags are held clear, so busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Cylinder address strobe from host, active high |
| cyl_addr_i | input | 9 | Cylinder address, stable while strobe is active |
| restore_req_i | input | 1 | Restore request, sampled at strobe trailing edge |
| sel_ready_i | input | 1 | Drive selected and ready |
| ready_i | input | 1 | Drive ready; low clears busy |
| heads_loaded_i | input | 1 | Heads loaded; low clears illegal flag |
| pos_mode_i | input | 1 | Servo position mode; low means address difference nonzero |
| settle_tick_i | input | 1 | Slow synchronous tick advancing the settle chain |
| load_pulse_o | output | 1 | One-clock demand register load |
| restore_start_o | output | 1 | One-clock restore start |
| restore_o | output | 1 | Restore in progress |
| busy_o | output | 1 | Busy status to host |
| illegal_o | output | 1 | Illegal address status to host |
| end_busy_o | output | 1 | One-clock end of seek or restore |

## Verification
The assertions check four relations on every cycle. The single-clock width of the address pulse and the immediate set of hold-busy while a strobe is active are checked. So is the masking of illegal_o during the second strobe stage. Finally, seek-busy must follow position-mode edges, end-busy and ready, and the settle chain must not move without a tick. Only the bench scenarios can show whole command outcomes. These include a strobe rejected while a seek is busy, the exact window in which busy is held, and whether a restore disregards an out-of-range address. They also include seek-busy that outlasts a settle interval whose ticks are withheld, and the clearing of the illegal flag by load, restore or heads unloading.

// File: rtl/seek_accept_pkg.sv
package seek_accept_pkg;
  localparam int DEF_ADDR_W     = 9;
  localparam int DEF_MAX_CYL    = 405;
  localparam int DEF_HOLD_LEN   = 4;
  localparam int DEF_SETTLE_LEN = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // bit positions inside the synchronizer bundle
  localparam int SB_STROBE  = 0;
  localparam int SB_RESTORE = 1;
  localparam int SB_SEL     = 2;
  localparam int SB_READY   = 3;
  localparam int SB_POS     = 4;
  localparam int SB_HEADS   = 5;
  localparam int SB_W       = 6;
endpackage

// File: rtl/seek_sync.sv
module seek_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= '0;
        else         ff_q[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= '0;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/strobe_stage.sv
module strobe_stage #(
  parameter int HOLD_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_s_i,
  input  logic sel_s_i,
  input  logic ready_s_i,
  output logic stage_a_o,
  output logic stage_b_o,
  output logic addr_pulse_o,
  output logic hold_busy_o
);
  localparam logic [HOLD_LEN-1:0] HD_ONE = HOLD_LEN'(1);

  logic [1:0]          stb_q;
  logic [HOLD_LEN-1:0] hd_q;
  logic                hold_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stb_q <= '0;
    else if (!sel_s_i) stb_q <= '0;
    else              stb_q <= {stb_q[0], strobe_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_busy_q <= 1'b0;
    else if (!ready_s_i)        hold_busy_q <= 1'b0;
    else if (stb_q[0])          hold_busy_q <= 1'b1;
    else if (hd_q[HOLD_LEN-1])  hold_busy_q <= 1'b0;
  end

  // hold chain only fills after the strobe is gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hd_q <= '0;
    else if (stb_q[0] || !hold_busy_q) hd_q <= '0;
    else                               hd_q <= (hd_q << 1) | HD_ONE;
  end

  assign stage_a_o    = stb_q[0];
  assign stage_b_o    = stb_q[1];
  assign addr_pulse_o = stb_q[1] & ~stb_q[0];
  assign hold_busy_o  = hold_busy_q;

  AST_HOLD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q[0] && ready_s_i |=> hold_busy_q); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_pulse_o |=> !addr_pulse_o); // R3
  AST_STB_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s_i |=> !addr_pulse_o); // R1
endmodule

// File: rtl/seek_settle.sv
module seek_settle #(
  parameter int SETTLE_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_s_i,
  input  logic ready_s_i,
  input  logic tick_i,
  input  logic end_i,
  output logic seek_busy_o,
  output logic settle_done_o
);
  localparam logic [SETTLE_LEN-1:0] SD_ONE = SETTLE_LEN'(1);

  logic                  pos_prev_q;
  logic                  seek_busy_q;
  logic [SETTLE_LEN-1:0] sd_q;
  logic                  pos_fall;

  assign pos_fall = pos_prev_q & ~pos_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_prev_q <= 1'b0;
    else         pos_prev_q <= pos_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seek_busy_q <= 1'b0;
    else if (!ready_s_i) seek_busy_q <= 1'b0;
    else if (pos_fall)   seek_busy_q <= 1'b1;
    else if (end_i)      seek_busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sd_q <= '0;
    else if (!pos_s_i) sd_q <= '0;
    else if (tick_i)   sd_q <= (sd_q << 1) | SD_ONE;
  end

  assign seek_busy_o   = seek_busy_q;
  assign settle_done_o = sd_q[SETTLE_LEN-1];

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_fall && ready_s_i |=> seek_busy_q); // R8
  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !pos_fall |=> !seek_busy_q); // R9
  AST_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_s_i |=> !seek_busy_q); // R10
  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_s_i && !tick_i |=> $stable(sd_q)); // R9
endmodule

// File: rtl/seek_accept_ctrl.sv
module seek_accept_ctrl
  import seek_accept_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int MAX_CYL     = DEF_MAX_CYL,
  parameter int HOLD_LEN    = DEF_HOLD_LEN,
  parameter int SETTLE_LEN  = DEF_SETTLE_LEN,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] cyl_addr_i,
  input  logic              restore_req_i,
  input  logic              sel_ready_i,
  input  logic              ready_i,
  input  logic              heads_loaded_i,
  input  logic              pos_mode_i,
  input  logic              settle_tick_i,
  output logic              load_pulse_o,
  output logic              restore_start_o,
  output logic              restore_o,
  output logic              busy_o,
  output logic              illegal_o,
  output logic              end_busy_o
);
  localparam logic [ADDR_W-1:0] MAX_ADDR = ADDR_W'(MAX_CYL);

  logic [SB_W-1:0] raw, syn;
  logic stage_a, stage_b, addr_pulse, hold_busy;
  logic seek_busy, settle_done;
  logic addr_ok, ill_set;
  logic illegal_q, restore_q;

  assign raw[SB_STROBE]  = strobe_i;
  assign raw[SB_RESTORE] = restore_req_i;
  assign raw[SB_SEL]     = sel_ready_i;
  assign raw[SB_READY]   = ready_i;
  assign raw[SB_POS]     = pos_mode_i;
  assign raw[SB_HEADS]   = heads_loaded_i;

  seek_sync #(.W(SB_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  strobe_stage #(.HOLD_LEN(HOLD_LEN)) i_strobe (
    .clk_i, .rst_ni,
    .strobe_s_i  (syn[SB_STROBE]),
    .sel_s_i     (syn[SB_SEL]),
    .ready_s_i   (syn[SB_READY]),
    .stage_a_o   (stage_a),
    .stage_b_o   (stage_b),
    .addr_pulse_o(addr_pulse),
    .hold_busy_o (hold_busy)
  );

  seek_settle #(.SETTLE_LEN(SETTLE_LEN)) i_settle (
    .clk_i, .rst_ni,
    .pos_s_i      (syn[SB_POS]),
    .ready_s_i    (syn[SB_READY]),
    .tick_i       (settle_tick_i),
    .end_i        (end_busy_o),
    .seek_busy_o  (seek_busy),
    .settle_done_o(settle_done)
  );

  assign addr_ok         = cyl_addr_i <= MAX_ADDR;
  assign restore_start_o = addr_pulse & syn[SB_RESTORE];
  assign load_pulse_o    = addr_pulse & ~syn[SB_RESTORE] & addr_ok & ~seek_busy;
  assign ill_set         = addr_pulse & ~syn[SB_RESTORE] & (~addr_ok | seek_busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else if (!syn[SB_HEADS] || load_pulse_o || restore_start_o) illegal_q <= 1'b0;
    else if (ill_set) illegal_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              restore_q <= 1'b0;
    else if (restore_start_o) restore_q <= 1'b1;
    else if (end_busy_o)      restore_q <= 1'b0;
  end

  assign end_busy_o = settle_done & (seek_busy | restore_q);
  assign busy_o     = hold_busy | seek_busy;
  assign restore_o  = restore_q;
  assign illegal_o  = illegal_q & syn[SB_SEL] & ~stage_b;

  AST_ILLEGAL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_b |-> !illegal_o); // R7
  AST_LOAD_CLEARS_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_o |=> !illegal_q); // R6
  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_o |-> cyl_addr_i <= MAX_ADDR); // R3
  AST_RESTORE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_start_o |-> !load_pulse_o && !ill_set); // R4
  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn[SB_READY] |=> !busy_o); // R10
  AST_STAGE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_b) |-> $past(stage_a)); // R1
endmodule

// File: tb/test_seek_accept_ctrl.sv
module test_seek_accept_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, restore_req = 0, sel = 1, ready = 1, heads = 1, pos = 1, tick = 0;
  logic [8:0] addr = '0;
  logic load_p, rs_start, rs_act, busy, ill, end_b;
  logic tick_en = 1'b1, done = 1'b0;
  int n_chk = 0, n_fail = 0;
  int c_load = 0, c_rs = 0, c_end = 0;
  int phase = 0;
  logic mid_busy, mid_ill;

  always #2 clk = ~clk;

  seek_accept_ctrl i_seek_accept_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .cyl_addr_i(addr),
    .restore_req_i(restore_req), .sel_ready_i(sel), .ready_i(ready),
    .heads_loaded_i(heads), .pos_mode_i(pos), .settle_tick_i(tick),
    .load_pulse_o(load_p), .restore_start_o(rs_start), .restore_o(rs_act),
    .busy_o(busy), .illegal_o(ill), .end_busy_o(end_b)
  );

  // tick every 4th clock, driven off-edge
  always @(negedge clk) begin
    phase <= (phase + 1) % 4;
    tick  <= tick_en && (phase == 0);
  end

  always @(negedge clk) begin
    if (load_p)   c_load <= c_load + 1;
    if (rs_start) c_rs   <= c_rs + 1;
    if (end_b)    c_end  <= c_end + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_strobe(input logic [8:0] a, input logic rs);
    @(negedge clk);
    addr = a; restore_req = rs; strobe = 1'b1;
    waitn(6);
    mid_busy = busy; mid_ill = ill;
    strobe = 1'b0;
    waitn(16);
    restore_req = 1'b0;
  endtask

  typedef struct packed {
    logic [8:0] a;
    logic       rs;
    logic       ld;
    logic       il;
    logic       st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{a: 9'd0,   rs: 1'b0, ld: 1'b1, il: 1'b0, st: 1'b0},
    '{a: 9'd405, rs: 1'b0, ld: 1'b1, il: 1'b0, st: 1'b0},
    '{a: 9'd406, rs: 1'b0, ld: 1'b0, il: 1'b1, st: 1'b0},
    '{a: 9'd200, rs: 1'b0, ld: 1'b1, il: 1'b0, st: 1'b0},
    '{a: 9'd511, rs: 1'b0, ld: 1'b0, il: 1'b1, st: 1'b0},
    '{a: 9'd300, rs: 1'b1, ld: 1'b0, il: 1'b0, st: 1'b1}
  };

  initial begin
    int l0, r0, e0;
    waitn(3);
    chk("R10 reset busy", busy, 0);
    chk("R3 reset load", load_p, 0);
    chk("R7 reset illegal", ill, 0);
    rst_n = 1'b1;
    waitn(60);

    // R3 R4 R5 R6: table walk, position mode held high (no seek)
    for (int i = 0; i < 6; i++) begin
      l0 = c_load; r0 = c_rs;
      do_strobe(VECS[i].a, VECS[i].rs);
      chk("R3 load count", c_load - l0, int'(VECS[i].ld));
      chk("R4 restore count", c_rs - r0, int'(VECS[i].st));
      chk("R5 illegal after strobe", ill, int'(VECS[i].il));
      chk("R2 busy mid strobe", mid_busy, 1);
      chk("R2 busy released", busy, 0);
    end

    // R2: busy held a few clocks after trailing edge
    @(negedge clk); addr = 9'd10; strobe = 1'b1;
    waitn(6); strobe = 1'b0;
    waitn(4);
    chk("R2 busy hold window", busy, 1);
    waitn(14);
    chk("R2 busy dropped", busy, 0);

    // R8: seek
    do_strobe(9'd100, 1'b0);
    @(negedge clk); pos = 1'b0;
    waitn(20);
    chk("R8 seek busy", busy, 1);
    l0 = c_load;
    do_strobe(9'd50, 1'b0);
    chk("R5 no load while seeking", c_load - l0, 0);
    chk("R5 illegal while seeking", ill, 1);
    // R9: no ticks, busy stays
    tick_en = 1'b0; e0 = c_end;
    @(negedge clk); pos = 1'b1;
    waitn(60);
    chk("R9 busy without ticks", busy, 1);
    tick_en = 1'b1;
    waitn(60);
    chk("R9 end pulse", c_end - e0, 1);
    chk("R9 busy cleared", busy, 0);

    // R7: masked during second stage, gated by selected-ready
    do_strobe(9'd450, 1'b0);
    chk("R7 masked mid strobe", mid_ill, 0);
    chk("R7 illegal shown", ill, 1);
    @(negedge clk); sel = 1'b0;
    waitn(6);
    chk("R7 gated by sel", ill, 0);
    // R1: strobe ignored while not selected
    l0 = c_load;
    do_strobe(9'd20, 1'b0);
    chk("R1 no busy when unselected", mid_busy, 0);
    chk("R1 no load when unselected", c_load - l0, 0);
    @(negedge clk); sel = 1'b1;
    waitn(6);
    chk("R1 illegal kept", ill, 1);

    // R6: heads unload clears illegal
    @(negedge clk); heads = 1'b0;
    waitn(6);
    chk("R6 heads clears illegal", ill, 0);
    @(negedge clk); heads = 1'b1;
    waitn(4);

    // R10: ready low clears busy
    do_strobe(9'd120, 1'b0);
    @(negedge clk); pos = 1'b0;
    waitn(10);
    chk("R10 busy before ready drop", busy, 1);
    @(negedge clk); ready = 1'b0;
    waitn(8);
    chk("R10 busy cleared by ready", busy, 0);
    @(negedge clk); ready = 1'b1; pos = 1'b1;
    waitn(60);

    // R4 R9: restore during seek, out-of-range address disregarded
    @(negedge clk); pos = 1'b0;
    waitn(10);
    l0 = c_load; r0 = c_rs;
    do_strobe(9'd480, 1'b1);
    chk("R4 restore start", c_rs - r0, 1);
    chk("R4 no load on restore", c_load - l0, 0);
    chk("R4 no illegal on restore", ill, 0);
    chk("R4 restore active", rs_act, 1);
    @(negedge clk); pos = 1'b1;
    waitn(60);
    chk("R9 restore ended", rs_act, 0);
    chk("R9 busy after restore", busy, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule